// File: doc/BRIEF.md
# Sixteen-bit Shift Unit with Flag Generation

This block performs one of three shifts on a 16-bit operand: shift left, logical shift right (zero fill) and arithmetic shift right (sign fill). Each request carries an operand, an 8-bit shift amount and a 2-bit operation select, qualified by `in_valid`. One clock later the block presents the shifted word, a write-enable for the destination, and six status flags (carry, parity, auxiliary carry, zero, sign, overflow), each with its own update enable. An execution pipeline uses it by writing the result and merging the enabled flags into its status word.

Only the low five bits of the shift amount count. A masked amount of zero, or the reserved operation select, leaves the destination and all flags untouched: every enable is low. Shift amounts from 17 to 31 have a defined outcome for all three shifts, so no input combination leaves the outputs undefined.

The datapath is purely combinational and feeds a single register stage. It has no states and no transitions beyond that stage: `out_valid` is `in_valid` delayed by one cycle.

Top module: `shift_unit`

## Requirements
- R1: The shift amount is taken modulo 32 (low five bits of `in_cnt`); an amount of 0x21 gives the same outputs as 0x01.
- R2: A masked amount of zero produces `out_wr_en` = 0, `out_flag_en` = 0 and `out_result` equal to the operand.
- R3: Operation select 2'b11 is a no-operation with the same outputs as R2; 2'b00 is shift left, 2'b01 logical right, 2'b10 arithmetic right.
- R4: Shift left by n in 1..16 gives operand << n (truncated to 16 bits), carry = operand bit (16 − n), overflow = carry XOR result bit 15.
- R5: Shift left by 17..31 gives result 0 with carry 0 and overflow 0.
- R6: Logical right by n gives operand >> n with zero fill, carry = operand bit (n − 1) (0 when n − 1 > 15), overflow = result bit 15 XOR result bit 14.
- R7: Arithmetic right by n fills with the sign bit; carry = bit (n − 1) of the sign-extended operand (the sign bit for n ≥ 16); overflow is always 0.
- R8: Zero, sign and parity come from the 16-bit result (parity = 1 when the low byte holds an even number of ones); auxiliary carry is 0 on every executed shift. `out_flags`/`out_flag_en` bit order: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow.
- R9: Every executed shift drives `out_wr_en` = 1 and all six bits of `out_flag_en` = 1.
- R10: `out_valid` equals `in_valid` of the previous cycle, and the outputs then reflect that cycle's request; a synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| in_opnd | input | 16 | Operand to shift |
| in_cnt | input | 8 | Shift amount, low five bits used |
| in_op | input | 2 | Operation select |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 16 | Shifted word |
| out_wr_en | output | 1 | Destination write enable |
| out_flags | output | 6 | Flag values, order per R8 |
| out_flag_en | output | 6 | Per-flag update enables |

## Verification
The bench targets the edges of the amount range: 1, 15, 16, 17 and 31 for each shift, plus amounts whose upper bits must be ignored. A design that failed to mask would treat 0x21 as a large shift and zero the word. A design that let the left shift wrap or carry past 16 would return a nonzero result or a stale carry for 17..31. A design that read the carry past bit 15 without sign extension would report 0 for a negative operand shifted right arithmetically by 16 or more. Zero amounts and the reserved select are driven with operands that would set flags, so a leaked write or flag enable shows up at the ports.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SHR = 2'b01,
        OP_SAR = 2'b10,
        OP_NOP = 2'b11
    } shift_op_e;

    localparam int NUM_FLAGS = 6;
    localparam int FLG_CF    = 0;
    localparam int FLG_PF    = 1;
    localparam int FLG_AF    = 2;
    localparam int FLG_ZF    = 3;
    localparam int FLG_SF    = 4;
    localparam int FLG_OF    = 5;

endpackage

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int W    = 16,
    parameter int CNTW = 8,
    parameter int USEW = 5
) (
    input  logic [W-1:0]    opnd,
    input  logic [CNTW-1:0] cnt,
    input  shift_op_e       op,
    output logic [W-1:0]    res,
    output logic            cf,
    output logic            of,
    output logic            active
);
    localparam int WIDE = 2 * W;

    logic [USEW-1:0] amt;
    logic [WIDE-1:0] left_ext;
    logic [WIDE-1:0] lrgt_ext;
    logic [WIDE-1:0] argt_ext;

    assign amt = cnt[USEW-1:0];

    // Double-width shifts: the bit that falls out lands next to the result.
    assign left_ext = {{W{1'b0}}, opnd} << amt;
    assign lrgt_ext = {opnd, {W{1'b0}}} >> amt;
    assign argt_ext = WIDE'($signed({opnd, {W{1'b0}}}) >>> amt);

    assign active = (amt != '0) && (op != OP_NOP);

    always_comb begin
        res = opnd;
        cf  = 1'b0;
        of  = 1'b0;
        if (active) begin
            unique case (op)
                OP_SHL: begin
                    res = left_ext[W-1:0];
                    cf  = left_ext[W];
                    of  = left_ext[W] ^ left_ext[W-1];
                end
                OP_SHR: begin
                    res = lrgt_ext[WIDE-1:W];
                    cf  = lrgt_ext[W-1];
                    of  = lrgt_ext[WIDE-1] ^ lrgt_ext[WIDE-2];
                end
                OP_SAR: begin
                    res = argt_ext[WIDE-1:W];
                    cf  = argt_ext[W-1];
                    of  = 1'b0;
                end
                OP_NOP: begin
                    res = opnd;
                end
            endcase
        end
    end

endmodule

// File: rtl/shift_flags.sv
module shift_flags #(
    parameter int W  = 16,
    parameter int PW = 8
) (
    input  logic [W-1:0] res,
    output logic         zf,
    output logic         sf,
    output logic         pf
);
    assign zf = (res == '0);
    assign sf = res[W-1];
    assign pf = ~(^res[PW-1:0]);
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int W    = 16,
    parameter int CNTW = 8,
    parameter int USEW = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [W-1:0]         in_opnd,
    input  logic [CNTW-1:0]      in_cnt,
    input  logic [1:0]           in_op,
    output logic                 out_valid,
    output logic [W-1:0]         out_result,
    output logic                 out_wr_en,
    output logic [NUM_FLAGS-1:0] out_flags,
    output logic [NUM_FLAGS-1:0] out_flag_en
);
    shift_op_e             op_q;
    logic [W-1:0]          nx_res;
    logic                  nx_cf, nx_of, nx_act;
    logic                  nx_zf, nx_sf, nx_pf;
    logic [NUM_FLAGS-1:0]  nx_flags;

    assign op_q = shift_op_e'(in_op);

    shift_core #(.W(W), .CNTW(CNTW), .USEW(USEW)) u_core (
        .opnd   (in_opnd),
        .cnt    (in_cnt),
        .op     (op_q),
        .res    (nx_res),
        .cf     (nx_cf),
        .of     (nx_of),
        .active (nx_act)
    );

    shift_flags #(.W(W), .PW(8)) u_flags (
        .res (nx_res),
        .zf  (nx_zf),
        .sf  (nx_sf),
        .pf  (nx_pf)
    );

    always_comb begin
        nx_flags         = '0;
        nx_flags[FLG_CF] = nx_cf;
        nx_flags[FLG_PF] = nx_pf;
        nx_flags[FLG_AF] = 1'b0;
        nx_flags[FLG_ZF] = nx_zf;
        nx_flags[FLG_SF] = nx_sf;
        nx_flags[FLG_OF] = nx_of;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_wr_en   <= 1'b0;
            out_flags   <= '0;
            out_flag_en <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= nx_res;
                out_wr_en   <= nx_act;
                out_flags   <= nx_flags;
                out_flag_en <= {NUM_FLAGS{nx_act}};
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R2
    no_write_no_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_wr_en) |-> (out_flag_en == '0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10) |=> !out_flags[FLG_OF]);

    // R5
    left_far_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00 && in_cnt[USEW-1:0] > USEW'(W))
        |=> (out_result == '0 && !out_flags[FLG_CF]));

    // R8
    aux_clear_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_flags[FLG_AF]);

endmodule

// File: tb/shift_unit_bench.sv
`timescale 1ns/1ps
module shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_opnd;
    logic [7:0]  in_cnt;
    logic [1:0]  in_op;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_wr_en;
    logic [5:0]  out_flags;
    logic [5:0]  out_flag_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    shift_unit u_shift_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
        .in_cnt(in_cnt), .in_op(in_op), .out_valid(out_valid),
        .out_result(out_result), .out_wr_en(out_wr_en),
        .out_flags(out_flags), .out_flag_en(out_flag_en)
    );

    // {op[1:0], cnt[7:0], opnd[15:0]}
    localparam int NV = 24;
    localparam logic [25:0] VEC [NV] = '{
        {2'b00, 8'd1,  16'h8001}, {2'b00, 8'd1,  16'h4000},
        {2'b00, 8'd15, 16'h0003}, {2'b00, 8'd16, 16'h0001},
        {2'b00, 8'd16, 16'hFFFE}, {2'b00, 8'd17, 16'hFFFF},
        {2'b00, 8'd31, 16'hA5A5}, {2'b00, 8'h21, 16'h1234},
        {2'b01, 8'd1,  16'h8001}, {2'b01, 8'd1,  16'hC000},
        {2'b01, 8'd4,  16'hF0F8}, {2'b01, 8'd16, 16'h8000},
        {2'b01, 8'd17, 16'hFFFF}, {2'b01, 8'hE3, 16'h00FF},
        {2'b10, 8'd1,  16'h8001}, {2'b10, 8'd3,  16'h7FF4},
        {2'b10, 8'd15, 16'h8000}, {2'b10, 8'd16, 16'h8000},
        {2'b10, 8'd31, 16'h9000}, {2'b10, 8'd20, 16'h4000},
        {2'b00, 8'h40, 16'hFFFF}, {2'b01, 8'h20, 16'h8001},
        {2'b11, 8'd3,  16'h8001}, {2'b11, 8'd0,  16'h0000}
    };

    // Bit-serial model, written from the requirements.
    task automatic model(input logic [1:0] op, input logic [7:0] cnt,
                         input logic [15:0] v, output logic [15:0] r,
                         output logic wr, output logic [5:0] fl);
        int n;
        logic c;
        logic o;
        n = int'(cnt % 8'd32);
        r = v; c = 1'b0; o = 1'b0; fl = '0;
        wr = (n != 0) && (op != 2'b11);
        if (wr) begin
            for (int k = 0; k < n; k++) begin
                case (op)
                    2'b00:   begin c = r[15]; r = {r[14:0], 1'b0}; end
                    2'b01:   begin c = r[0];  r = {1'b0, r[15:1]}; end
                    default: begin c = r[0];  r = {r[15], r[15:1]}; end
                endcase
            end
            case (op)
                2'b00:   o = c ^ r[15];
                2'b01:   o = r[15] ^ r[14];
                default: o = 1'b0;
            endcase
            fl[0] = c;
            fl[1] = ~(^r[7:0]);
            fl[2] = 1'b0;
            fl[3] = (r == 16'h0);
            fl[4] = r[15];
            fl[5] = o;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [7:0] cnt, input logic [15:0] v,
                       input string req);
        logic [15:0] er;
        logic ew;
        logic [5:0] ef;
        model(op, cnt, v, er, ew, ef);
        in_valid = 1'b1; in_op = op; in_cnt = cnt; in_opnd = v;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R10 valid"}, 32'(out_valid), 32'd1);
        check({req, " result"}, 32'(out_result), 32'(ew ? er : v));
        check({req, " R9 wr_en"}, 32'(out_wr_en), 32'(ew));
        check({req, " R9 flag_en"}, 32'(out_flag_en), 32'(ew ? 6'h3F : 6'h00));
        if (ew) check({req, " R8 flags"}, 32'(out_flags), 32'(ef));
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_opnd = '0; in_cnt = '0; in_op = '0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 idle valid", 32'(out_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            case (VEC[i][25:24])
                2'b00: tag = (VEC[i][20:16] > 5'd16) ? "R5" : "R4";
                2'b01: tag = "R6";
                2'b10: tag = "R7";
                default: tag = "R3";
            endcase
            if (VEC[i][20:16] == 5'd0) tag = "R2";
            if (VEC[i][23:21] != 3'd0) tag = {tag, " R1"};
            run(VEC[i][25:24], VEC[i][23:16], VEC[i][15:0], tag);
        end

        // Directed hand-derived cases
        in_valid = 1'b1; in_op = 2'b00; in_cnt = 8'd1; in_opnd = 16'h8001;
        @(negedge clk); in_valid = 1'b0;
        check("R4 shl1 result", 32'(out_result), 32'h0002);
        check("R4 shl1 cf/of", 32'({out_flags[5], out_flags[0]}), 32'b11);

        in_valid = 1'b1; in_op = 2'b10; in_cnt = 8'd20; in_opnd = 16'h8000;
        @(negedge clk); in_valid = 1'b0;
        check("R7 sar20 result", 32'(out_result), 32'hFFFF);
        check("R7 sar20 cf/of", 32'({out_flags[5], out_flags[0]}), 32'b01);

        in_valid = 1'b1; in_op = 2'b01; in_cnt = 8'd1; in_opnd = 16'h8000;
        @(negedge clk); in_valid = 1'b0;
        check("R6 shr1 result", 32'(out_result), 32'h4000);
        check("R6 shr1 of/cf", 32'({out_flags[5], out_flags[0]}), 32'b10);

        in_valid = 1'b1; in_op = 2'b00; in_cnt = 8'h21; in_opnd = 16'h0001;
        @(negedge clk); in_valid = 1'b0;
        check("R1 masked shl result", 32'(out_result), 32'h0002);

        in_valid = 1'b1; in_op = 2'b01; in_cnt = 8'h20; in_opnd = 16'hFFFF;
        @(negedge clk); in_valid = 1'b0;
        check("R2 zero amt wr_en", 32'(out_wr_en), 32'd0);
        check("R2 zero amt result", 32'(out_result), 32'hFFFF);

        @(negedge clk);
        check("R10 gap valid", 32'(out_valid), 32'd0);

        in_valid = 1'b1; rst = 1'b1; in_op = 2'b00; in_cnt = 8'd1;
        @(negedge clk);
        check("R10 reset mid-run", 32'(out_valid), 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule